// File: doc/BRIEF.md
# Connection Memory Block Initializer

This block loads a fixed pattern into every location of the two connection memories of a time-slot switch. The backplane memory has one 16-bit bank. The local memory has a low bank and a high bank, and each of them is 16 bits wide. Software writes a mode register that holds three fields: a 3-bit backplane pattern, a 4-bit local pattern and a begin bit. A separate control input must also permit block programming. When both conditions are met, the block sweeps the whole address range one address per clock. On each address it writes a pattern word into all three banks at once.

The sweep is timed by frames rather than by its own length. It ends on the second frame pulse after the start. At that moment the begin bit clears itself, so software that polls the begin bit sees 0 when the operation is over. Software can abort a sweep that is running in two ways: by writing the begin bit back to 0, or by removing the programming permission. Words already written keep their new value.

Top module: `cmem_fill_ctrl`

## Requirements
- R1: A sweep starts only when a register write changes the begin bit from 0 to 1 while `blk_prog_en` is 1. A write of 1 while `blk_prog_en` is 0 is stored and readable but starts nothing. A later write of 1 onto a stored 1 also starts nothing.
- R2: Every backplane write word carries the backplane pattern in bits 13..11, and all of its other bits are 0.
- R3: Every local-low write word carries the local pattern in bits 15..12, and bits 11..0 are 0.
- R4: Every local-high write word is all zeros.
- R5: All three write strobes are active in the same cycles and share `mem_addr`. The first strobe follows the starting write by one clock. The address begins at 0 and rises by one each clock, so each of the DEPTH addresses is written exactly once.
- R6: A sweep ends on the second `frame_pulse` that the block samples after the start. `begin_rb` reads 1 up to and including that cycle and reads 0 from the next cycle. If the address range has not been covered by then, the strobes still stop at that point.
- R7: A register write with the begin bit at 0 during a sweep stops the strobes from the next cycle, and `begin_rb` reads 0.
- R8: Dropping `blk_prog_en` during a sweep removes the strobes in the same cycle, and `begin_rb` reads 0 from the next cycle.
- R9: While a sweep runs, a register write with the begin bit at 1 has no effect. The pattern words keep the values captured at the start.
- R10: In the mode register word, the local pattern sits in bits 6..3, the backplane pattern in bits 9..7 and the begin bit in bit 2. Bits 1 and 0 have no effect on this block. After reset, `begin_rb` is 0 and no strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_pulse | input | 1 | One-cycle frame boundary marker |
| reg_wr | input | 1 | Mode register write strobe |
| reg_wdata | input | 16 | Mode register write data |
| blk_prog_en | input | 1 | Control bit that permits block programming |
| mem_addr | output | AW | Address shared by all three banks |
| bp_we | output | 1 | Backplane bank write strobe |
| bp_wdata | output | 16 | Backplane bank write word |
| lo_we | output | 1 | Local-low bank write strobe |
| lo_wdata | output | 16 | Local-low bank write word |
| hi_we | output | 1 | Local-high bank write strobe |
| hi_wdata | output | 16 | Local-high bank write word |
| begin_rb | output | 1 | Readback of the begin bit |

## Verification
A corrupted sequencer state shows up at the ports in the first cycle after it occurs. Depending on the fault, there is a missing or extra strobe, an address that skips or repeats, or `begin_rb` falling on the wrong frame pulse. The strobe count per sweep and the cycle in which `begin_rb` falls are both checked exactly. A pattern register that changes while a sweep runs alters the very next word written, and each word is compared against the value captured at the start. Abort faults appear within one clock, because the strobes must stop in the same cycle or the next one.

// File: rtl/cmem_fill_pkg.sv
package cmem_fill_pkg;

    localparam int REG_W     = 16;
    localparam int WORD_W    = 16;
    localparam int BP_PAT_W  = 3;
    localparam int LO_PAT_W  = 4;
    localparam int LO_LSB    = 3;
    localparam int BP_LSB    = 7;
    localparam int BEGIN_BIT = 2;
    localparam int BP_WORD_LSB = 11;
    localparam int LO_WORD_LSB = 12;
    localparam int N_BANKS   = 3;

    typedef struct packed {
        logic [BP_PAT_W-1:0] bp_pat;
        logic [LO_PAT_W-1:0] lo_pat;
    } fill_pat_t;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_SWEEP = 2'd1,
        SEQ_WAIT  = 2'd2
    } seq_state_t;

    typedef logic [WORD_W-1:0] bank_word_t;

    function automatic fill_pat_t decode_pat(input logic [REG_W-1:0] w);
        fill_pat_t p;
        p.bp_pat = w[BP_LSB +: BP_PAT_W];
        p.lo_pat = w[LO_LSB +: LO_PAT_W];
        return p;
    endfunction

    // bank index: 0 backplane, 1 local low, 2 local high
    function automatic bank_word_t form_word(input fill_pat_t p, input int bank);
        bank_word_t w;
        w = '0;
        if (bank == 0)
            w[BP_WORD_LSB +: BP_PAT_W] = p.bp_pat;
        else if (bank == 1)
            w[LO_WORD_LSB +: LO_PAT_W] = p.lo_pat;
        return w;
    endfunction

endpackage

// File: rtl/cmem_fill_modereg.sv
module cmem_fill_modereg
    import cmem_fill_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic             blk_prog_en,
    input  logic             seq_active,
    input  logic             seq_clear,
    output logic             begin_q,
    output fill_pat_t        pat_q,
    output logic             start_req,
    output logic             sw_abort
);

    logic wr_begin;
    logic wr_take;
    logic unused_bits;

    assign wr_begin    = reg_wdata[BEGIN_BIT];
    assign unused_bits = ^{reg_wdata[REG_W-1:BP_LSB+BP_PAT_W], reg_wdata[BEGIN_BIT-1:0]};

    // during a sweep a write keeping begin=1 is discarded
    assign wr_take   = reg_wr && !(seq_active && wr_begin);
    assign start_req = reg_wr && wr_begin && !begin_q && blk_prog_en;
    assign sw_abort  = reg_wr && !wr_begin && seq_active;

    always_ff @(posedge clk) begin
        if (rst) begin
            begin_q <= 1'b0;
            pat_q   <= '0;
        end else if (wr_take) begin
            begin_q <= wr_begin;
            pat_q   <= decode_pat(reg_wdata);
        end else if (seq_clear) begin
            begin_q <= 1'b0;
        end
    end

endmodule

// File: rtl/cmem_fill_seq.sv
module cmem_fill_seq
    import cmem_fill_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_req,
    input  logic          sw_abort,
    input  logic          blk_prog_en,
    input  logic          frame_pulse,
    output logic          active,
    output logic          clear_req,
    output logic          wr_en,
    output logic [AW-1:0] addr
);

    localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

    seq_state_t    state_q;
    logic [AW-1:0] addr_q;
    logic          one_frame_q;
    logic          hw_abort;
    logic          finish;

    assign active    = (state_q != SEQ_IDLE);
    assign hw_abort  = active && !blk_prog_en;
    assign finish    = active && frame_pulse && one_frame_q;
    assign clear_req = finish || hw_abort;
    assign wr_en     = (state_q == SEQ_SWEEP) && blk_prog_en;
    assign addr      = addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= SEQ_IDLE;
            addr_q      <= '0;
            one_frame_q <= 1'b0;
        end else if (start_req) begin
            state_q     <= SEQ_SWEEP;
            addr_q      <= '0;
            one_frame_q <= 1'b0;
        end else if (sw_abort || hw_abort || finish) begin
            state_q     <= SEQ_IDLE;
            addr_q      <= '0;
            one_frame_q <= 1'b0;
        end else if (active) begin
            if (frame_pulse)
                one_frame_q <= 1'b1;
            if (state_q == SEQ_SWEEP) begin
                if (addr_q == LAST_ADDR) begin
                    state_q <= SEQ_WAIT;
                    addr_q  <= '0;
                end else begin
                    addr_q <= addr_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/cmem_fill_words.sv
module cmem_fill_words
    import cmem_fill_pkg::*;
(
    input  fill_pat_t  pat,
    input  logic       wr_en,
    output logic [N_BANKS-1:0] bank_we,
    output bank_word_t bank_wdata [N_BANKS]
);

    for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
        assign bank_we[b]    = wr_en;
        assign bank_wdata[b] = form_word(pat, b);
    end

endmodule

// File: rtl/cmem_fill_ctrl.sv
module cmem_fill_ctrl
    import cmem_fill_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_pulse,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic              blk_prog_en,
    output logic [AW-1:0]     mem_addr,
    output logic              bp_we,
    output logic [WORD_W-1:0] bp_wdata,
    output logic              lo_we,
    output logic [WORD_W-1:0] lo_wdata,
    output logic              hi_we,
    output logic [WORD_W-1:0] hi_wdata,
    output logic              begin_rb
);

    fill_pat_t          pat_q;
    logic               start_req;
    logic               sw_abort;
    logic               seq_active;
    logic               seq_clear;
    logic               wr_en;
    logic [N_BANKS-1:0] bank_we;
    bank_word_t         bank_wdata [N_BANKS];

    cmem_fill_modereg u_modereg (
        .clk        (clk),
        .rst        (rst),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .blk_prog_en(blk_prog_en),
        .seq_active (seq_active),
        .seq_clear  (seq_clear),
        .begin_q    (begin_rb),
        .pat_q      (pat_q),
        .start_req  (start_req),
        .sw_abort   (sw_abort)
    );

    cmem_fill_seq #(.DEPTH(DEPTH), .AW(AW)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start_req  (start_req),
        .sw_abort   (sw_abort),
        .blk_prog_en(blk_prog_en),
        .frame_pulse(frame_pulse),
        .active     (seq_active),
        .clear_req  (seq_clear),
        .wr_en      (wr_en),
        .addr       (mem_addr)
    );

    cmem_fill_words u_words (
        .pat       (pat_q),
        .wr_en     (wr_en),
        .bank_we   (bank_we),
        .bank_wdata(bank_wdata)
    );

    assign bp_we    = bank_we[0];
    assign lo_we    = bank_we[1];
    assign hi_we    = bank_we[2];
    assign bp_wdata = bank_wdata[0];
    assign lo_wdata = bank_wdata[1];
    assign hi_wdata = bank_wdata[2];

endmodule

// File: rtl/cmem_fill_chk.sv
module cmem_fill_chk #(
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst,
    input logic          frame_pulse,
    input logic          reg_wr,
    input logic [15:0]   reg_wdata,
    input logic          blk_prog_en,
    input logic [AW-1:0] mem_addr,
    input logic          bp_we,
    input logic [15:0]   bp_wdata,
    input logic          lo_we,
    input logic [15:0]   lo_wdata,
    input logic          hi_we,
    input logic [15:0]   hi_wdata,
    input logic          begin_rb
);

    a_r1_strobe_needs_begin: assert property (@(posedge clk) disable iff (rst)
        bp_we |-> begin_rb);

    a_r2_bp_word_shape: assert property (@(posedge clk) disable iff (rst)
        bp_we |-> (bp_wdata[15:14] == 2'b00 && bp_wdata[10:0] == 11'd0));

    a_r3_lo_word_shape: assert property (@(posedge clk) disable iff (rst)
        lo_we |-> (lo_wdata[11:0] == 12'd0));

    a_r4_hi_word_zero: assert property (@(posedge clk) disable iff (rst)
        hi_we |-> (hi_wdata == 16'd0));

    a_r5_addr_steps: assert property (@(posedge clk) disable iff (rst)
        (bp_we && $past(bp_we)) |-> ((mem_addr - $past(mem_addr)) == AW'(1)));

    a_r6_begin_fall_cause: assert property (@(posedge clk) disable iff (rst)
        $fell(begin_rb) |-> ($past(reg_wr) || !$past(blk_prog_en) || $past(frame_pulse)));

    a_r7_write_zero_stops: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !reg_wdata[2]) |=> (!bp_we && !begin_rb));

    a_r8_no_strobe_without_en: assert property (@(posedge clk) disable iff (rst)
        !blk_prog_en |-> (!bp_we && !lo_we && !hi_we));

    a_r9_pattern_stable: assert property (@(posedge clk) disable iff (rst)
        (bp_we && $past(bp_we)) |-> ($stable(bp_wdata) && $stable(lo_wdata)));

endmodule

bind cmem_fill_ctrl cmem_fill_chk #(.AW(AW)) u_chk (.*);

// File: tb/cmem_fill_ctrl_test.sv
module cmem_fill_ctrl_test;

    localparam int DEPTH = 64;
    localparam int AW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          frame_pulse = 1'b0;
    logic          reg_wr = 1'b0;
    logic [15:0]   reg_wdata = '0;
    logic          blk_prog_en = 1'b1;
    logic [AW-1:0] mem_addr;
    logic          bp_we, lo_we, hi_we, begin_rb;
    logic [15:0]   bp_wdata, lo_wdata, hi_wdata;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    cmem_fill_ctrl #(.DEPTH(DEPTH)) uut (.*);

    // {bp pattern, local pattern, second-pulse cycle, stray low bits}
    localparam logic [15:0] VEC [0:4] = '{
        {3'd5, 4'd10, 8'd100, 1'b0},
        {3'd0, 4'd15, 8'd100, 1'b1},
        {3'd7, 4'd0,  8'd90,  1'b0},
        {3'd2, 4'd9,  8'd30,  1'b1},
        {3'd3, 4'd6,  8'd64,  1'b0}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(input logic [2:0] bp, input logic [3:0] lp,
                                       input logic beg, input logic junk);
        return {6'd0, bp, lp, beg, junk, junk};
    endfunction

    // kind: 0 none, 1 write begin=0, 2 drop enable, 3 rewrite other pattern with begin=1
    task automatic sweep(input logic [2:0] bp, input logic [3:0] lp, input logic junk,
                         input int g2, input int ab_at, input int kind, input int exp_n);
        int n = 0;
        int bad = 0;
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = mk(bp, lp, 1'b1, junk);
        for (int j = 1; j <= g2 + 3; j++) begin
            @(negedge clk);
            reg_wr = 1'b0;
            frame_pulse = 1'b0;
            if (bp_we) begin
                if (!(lo_we && hi_we) || mem_addr != AW'(n)) bad++;
                if (bp_wdata != {2'b00, bp, 11'd0}) bad++;
                if (lo_wdata != {lp, 12'd0}) bad++;
                if (hi_wdata != 16'd0) bad++;
                n++;
            end else if (lo_we || hi_we) begin
                bad++;
            end
            if (kind == 0 && j == g2)
                check(begin_rb == 1'b1, "R6 begin held at second pulse", begin_rb, 1);
            if (kind == 0 && j == g2 + 1)
                check(begin_rb == 1'b0, "R6 begin cleared after second pulse", begin_rb, 0);
            if (kind != 0 && kind != 3 && j == ab_at + 1)
                check(begin_rb == 1'b0, kind == 1 ? "R7 begin after abort" : "R8 begin after abort",
                      begin_rb, 0);
            if (j == g2 / 2 || j == g2) frame_pulse = 1'b1;
            if (j == ab_at && kind == 1) begin
                reg_wr = 1'b1;
                reg_wdata = mk(bp, lp, 1'b0, 1'b0);
            end
            if (j == ab_at && kind == 2) blk_prog_en = 1'b0;
            if (j == ab_at && kind == 3) begin
                reg_wr = 1'b1;
                reg_wdata = mk(~bp, ~lp, 1'b1, 1'b0);
            end
        end
        check(bad == 0, "R2 R3 R4 R5 R9 R10 word/address content", bad, 0);
        check(n == exp_n, "R5 R6 R7 R8 strobe count", n, exp_n);
        @(negedge clk);
        frame_pulse = 1'b0;
        reg_wr = 1'b0;
        blk_prog_en = 1'b1;
    endtask

    task automatic quiet(input int cycles, input string req);
        int n = 0;
        for (int j = 0; j < cycles; j++) begin
            @(negedge clk);
            reg_wr = 1'b0;
            if (bp_we || lo_we || hi_we) n++;
        end
        check(n == 0, req, n, 0);
    endtask

    initial begin
        #(4 * 200000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check(begin_rb == 1'b0, "R10 reset begin", begin_rb, 0);
        check(!(bp_we || lo_we || hi_we), "R10 reset strobes", bp_we, 0);

        // main vector table
        for (int v = 0; v < 5; v++) begin
            int g2;
            g2 = int'(VEC[v][8:1]);
            sweep(VEC[v][15:13], VEC[v][12:9], VEC[v][0], g2, -1, 0,
                  (g2 < DEPTH) ? g2 : DEPTH);
        end

        // R7 abort by writing begin=0
        sweep(3'd6, 4'd5, 1'b0, 30, 10, 1, 10);
        // R8 abort by dropping enable
        sweep(3'd1, 4'd3, 1'b0, 30, 5, 2, 5);
        // R9 write during sweep with begin=1 leaves patterns unchanged
        sweep(3'd4, 4'd12, 1'b0, 100, 5, 3, DEPTH);

        // R1 no start while enable is 0, begin stored
        @(negedge clk);
        blk_prog_en = 1'b0;
        reg_wr = 1'b1;
        reg_wdata = mk(3'd7, 4'd15, 1'b1, 1'b0);
        quiet(20, "R1 no sweep with enable low");
        check(begin_rb == 1'b1, "R1 begin stored without enable", begin_rb, 1);
        // R1 no edge: rewrite 1 onto stored 1 with enable high
        blk_prog_en = 1'b1;
        reg_wr = 1'b1;
        reg_wdata = mk(3'd7, 4'd15, 1'b1, 1'b0);
        quiet(20, "R1 no sweep without 0-to-1 edge");
        reg_wr = 1'b1;
        reg_wdata = mk(3'd0, 4'd0, 1'b0, 1'b0);
        @(negedge clk);
        reg_wr = 1'b0;
        check(begin_rb == 1'b0, "R10 begin bit cleared by write", begin_rb, 0);

        // R1 a fresh edge afterwards does start
        sweep(3'd5, 4'd1, 1'b0, 80, -1, 0, DEPTH);

        // R10 reset mid-sweep
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = mk(3'd2, 4'd2, 1'b1, 1'b0);
        @(negedge clk);
        reg_wr = 1'b0;
        check(bp_we == 1'b1, "R5 strobe one clock after start", bp_we, 1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(begin_rb == 1'b0 && !bp_we, "R10 reset clears sweep", begin_rb, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule